// File: doc/BRIEF.md
# Tagless-Hit Fetch Buffer

A small direct-mapped buffer of instruction lines that sits beside the first-level instruction cache. It does not compare tags on a fetch. It keeps guarantee bits that say, one fetch ahead, whether the next fetch group is certain to be resident. When the guarantee holds, the group is read from the buffer. The block then needs neither a tag check nor an address translation, and `access_l1` stays low. When no guarantee exists, `access_l1` goes high, the caller supplies the whole line from the first-level cache in the same cycle, and the buffer stores that line at the clock edge.

Each line holds four instructions. Each line has one bit saying that its sequential successor line is resident. Each instruction slot has one bit saying that it is a taken direct transfer whose target line is resident. Each line also keeps a vector of the lines that hold transfers aimed at it. When a line is replaced, those transfer bits are dropped. The vector may name lines that no longer point at it; that only costs a later refill. Instead of a full tag, only a short line ID is stored, because the first-level cache already resolves the higher address bits.

The caller presents one fetch per cycle: a word address, and how control leaves this group. The code on `next_kind` is 0 for sequential, 1 for a taken direct transfer in slot `br_slot` of the group, and 2 or 3 for any other redirect. Fetch groups are `FW` words wide and aligned to `FW`.

Top module: `thit_fetch_buf`

## Requirements
- R1: After reset all residency and guarantee state is empty, so the first fetch raises `access_l1`.
- R2: A fetch that follows a sequential group in the same line (last word of that group below 3) has `access_l1` low.
- R3: A sequential step out of a line (last word 3) is served by the buffer only when that line's next-line bit is set. After such a step is filled from the cache, the bit is set and a later identical traversal hits.
- R4: Replacing either line of a sequential pair clears the pair's next-line bit, so the next traversal of the pair raises `access_l1`.
- R5: A taken direct transfer (`next_kind`=1) whose target is not guaranteed fetches the target from the cache and sets the transfer's slot bit. Repeating the same transfer then reads the target from the buffer.
- R6: When a target line is replaced, every transfer bit recorded against it is cleared, and the next taken transfer to the old target raises `access_l1`.
- R7: The recorded position is the word at `br_slot` for a taken transfer, and the last word of the group for sequential flow. Transfers in different slots of one group keep separate bits.
- R8: After a fetch whose `next_kind` is 2 or 3, the following fetch always raises `access_l1`.
- R9: A cache fill into a line that already holds the same ID is a false miss. It clears no guarantee bits.
- R10: `fetch_words` carries the `FW`-aligned group that contains `fetch_pc`, with word 0 in the low bits. It comes from the buffer on a hit and from `l1_line` when `access_l1` is high.
- R11: Cycles with `fetch_valid` low change no state, and a fetch after idle cycles is judged against the last real fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch group is requested this cycle |
| fetch_pc | input | PC_W | Word address of the first instruction wanted |
| next_kind | input | 2 | How flow leaves this group: 0 sequential, 1 taken direct, 2/3 other |
| br_slot | input | SLOT_W | Slot of the taken direct transfer in the group |
| l1_line | input | 4*IW | Line from the first-level cache for `fetch_pc`, used when `access_l1` is high |
| access_l1 | output | 1 | No guarantee: the cache must be read and its line is written in |
| fetch_words | output | FW*IW | The aligned fetch group |

## Verification
A wrong guarantee does not stay hidden. If a guarantee bit is left set after its line is replaced, the next fetch on that path shows `access_l1` low together with words from the wrong address in `fetch_words`, in the same cycle as that fetch. If a bit is lost, `access_l1` rises on a path that should hit. The bench therefore checks both the access flag and the data of every fetch against an address-derived memory pattern. It runs pairs that are built, broken and rebuilt, a target line that is replaced, and transfers in both slots of one group.

// File: rtl/thit_fetch_buf.sv
module thit_fetch_buf #(
  parameter int PC_W  = 30,
  parameter int IW    = 32,
  parameter int LINES = 16,
  parameter int ID_W  = 4,
  parameter int FW    = 2,
  localparam int SLOT_W = (FW > 1) ? $clog2(FW) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic [PC_W-1:0]    fetch_pc,
  input  logic [1:0]         next_kind,
  input  logic [SLOT_W-1:0]  br_slot,
  input  logic [4*IW-1:0]    l1_line,
  output logic               access_l1,
  output logic [FW*IW-1:0]   fetch_words
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TOP   = 2 + IDX_W + ID_W;
  localparam logic [1:0] K_SEQ = 2'd0;
  localparam logic [1:0] K_DIR = 2'd1;

  logic [LINES-1:0][4*IW-1:0] line_q;
  logic [LINES-1:0][ID_W-1:0] id_q;
  logic [LINES-1:0]           valid_q;
  logic [LINES-1:0]           ns_q;
  logic [LINES-1:0][3:0]      nt_q;
  logic [LINES-1:0][LINES-1:0] tl_q;
  logic [1:0]                 prev_kind_q;
  logic [IDX_W-1:0]           prev_line_q;
  logic [1:0]                 prev_word_q;

  logic [IDX_W-1:0] cur_idx, below_idx;
  logic [1:0]       cur_word, base_word, last_word, br_word;
  logic [ID_W-1:0]  cur_id;
  logic             guar, fill, same, evict, seq_link, dir_link;
  logic [4*IW-1:0]  line_sel;

  generate
    if (PC_W > TOP) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^fetch_pc[PC_W-1:TOP];
    end
  endgenerate

  assign cur_word  = fetch_pc[1:0];
  assign cur_idx   = fetch_pc[2 +: IDX_W];
  assign cur_id    = fetch_pc[2+IDX_W +: ID_W];
  assign below_idx = cur_idx - 1'b1;
  assign base_word = cur_word & 2'(~(FW-1));
  assign last_word = base_word + 2'(FW-1);
  assign br_word   = base_word + 2'(br_slot);

  always_comb begin
    case (prev_kind_q)
      K_SEQ:   guar = (prev_word_q != 2'd3) ? 1'b1 : ns_q[prev_line_q];
      K_DIR:   guar = nt_q[prev_line_q][prev_word_q];
      default: guar = 1'b0;
    endcase
  end

  assign access_l1 = fetch_valid & ~guar;
  assign fill      = access_l1;
  assign same      = valid_q[cur_idx] && (id_q[cur_idx] == cur_id);
  assign evict     = fill & ~same;
  assign seq_link  = fill && prev_kind_q == K_SEQ && prev_word_q == 2'd3;
  assign dir_link  = fill && prev_kind_q == K_DIR && !(evict && prev_line_q == cur_idx);

  assign line_sel    = fill ? l1_line : line_q[cur_idx];
  assign fetch_words = line_sel[int'(base_word)*IW +: FW*IW];

  always_ff @(posedge clk) begin
    if (fetch_valid && fill) begin
      line_q[cur_idx] <= l1_line;
      id_q[cur_idx]   <= cur_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q     <= '0;
      ns_q        <= '0;
      nt_q        <= '0;
      tl_q        <= '0;
      prev_kind_q <= 2'd2;
      prev_line_q <= '0;
      prev_word_q <= '0;
    end else if (fetch_valid) begin
      if (fill) valid_q[cur_idx] <= 1'b1;
      if (evict) begin
        ns_q[cur_idx]   <= 1'b0;
        ns_q[below_idx] <= 1'b0;
        for (int j = 0; j < LINES; j++)
          if (tl_q[cur_idx][j]) nt_q[j] <= '0;
        nt_q[cur_idx] <= '0;
        tl_q[cur_idx] <= '0;
      end
      if (seq_link) ns_q[prev_line_q] <= 1'b1;
      if (dir_link) begin
        nt_q[prev_line_q][prev_word_q] <= 1'b1;
        tl_q[cur_idx][prev_line_q]     <= 1'b1;
      end
      prev_kind_q <= next_kind;
      prev_line_q <= cur_idx;
      prev_word_q <= (next_kind == K_DIR) ? br_word : last_word;
    end
  end
endmodule

module thit_fetch_buf_chk #(
  parameter int LINES = 16,
  parameter int FW    = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  fetch_valid,
  input logic [1:0]            next_kind,
  input logic [1:0]            pc_word,
  input logic [$clog2(LINES)-1:0] pc_idx,
  input logic                  access_l1,
  input logic [1:0]            prev_kind,
  input logic [$clog2(LINES)-1:0] prev_line,
  input logic [1:0]            prev_word,
  input logic [LINES-1:0][3:0] nt,
  input logic [LINES-1:0]      valid,
  input logic [LINES-1:0]      ns
);
  logic seen;
  logic [1:0] grp_last;
  assign grp_last = (pc_word & 2'(~(FW-1))) + 2'(FW-1);

  always_ff @(posedge clk)
    if (!rst_n) seen <= 1'b0;
    else if (fetch_valid) seen <= 1'b1;

  a_r1_first_fetch_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !seen) |-> access_l1);

  a_r2_inline_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fetch_valid) && $past(next_kind) == 2'd0 && $past(grp_last) != 2'd3 && fetch_valid)
      |-> !access_l1);

  a_r8_other_redirect_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fetch_valid) && $past(next_kind[1]) && fetch_valid) |-> access_l1);

  a_r5_target_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && access_l1 && prev_kind == 2'd1 && prev_line != pc_idx)
      |=> nt[$past(prev_line)][$past(prev_word)]);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> ($stable(valid) && $stable(nt) && $stable(ns)));
endmodule

bind thit_fetch_buf thit_fetch_buf_chk #(.LINES(LINES), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .next_kind(next_kind),
  .pc_word(fetch_pc[1:0]), .pc_idx(cur_idx), .access_l1(access_l1),
  .prev_kind(prev_kind_q), .prev_line(prev_line_q), .prev_word(prev_word_q),
  .nt(nt_q), .valid(valid_q), .ns(ns_q)
);

// File: tb/sim_thit_fetch_buf.sv
`timescale 1ns/1ps
module sim_thit_fetch_buf;
  localparam int PC_W = 30, IW = 32, LINES = 16, ID_W = 4, FW = 2;
  localparam int SLOT_W = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic [1:0] next_kind = 2'd0;
  logic [SLOT_W-1:0] br_slot = '0;
  logic [4*IW-1:0] l1_line;
  logic access_l1;
  logic [FW*IW-1:0] fetch_words;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { bit miss; logic [FW*IW-1:0] data; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  function automatic logic [IW-1:0] mword(input int a);
    return {16'(a) ^ 16'hC3A5, 16'(a)};
  endfunction

  always_comb
    for (int w = 0; w < 4; w++)
      l1_line[w*IW +: IW] = mword({fetch_pc[PC_W-1:2], 2'(w)});

  thit_fetch_buf #(.PC_W(PC_W), .IW(IW), .LINES(LINES), .ID_W(ID_W), .FW(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .next_kind(next_kind), .br_slot(br_slot), .l1_line(l1_line),
    .access_l1(access_l1), .fetch_words(fetch_words));

  task automatic fetch(input int pc, input int kind, input int slot, input bit miss, input string tag);
    exp_t e;
    int base;
    @(posedge clk); #1;
    fetch_valid = 1'b1;
    fetch_pc    = PC_W'(pc);
    next_kind   = 2'(kind);
    br_slot     = SLOT_W'(slot);
    base        = pc & ~(FW-1);
    e.miss = miss;
    for (int w = 0; w < FW; w++) e.data[w*IW +: IW] = mword(base + w);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      fetch_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && fetch_valid) begin
      exp_t e;
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: fetch with nothing expected, actual pc=%0d expected none", fetch_pc);
      end else begin
        e = q.pop_front();
        total++;
        if (access_l1 !== e.miss) begin
          bad++;
          $display("FAIL %s access_l1 pc=%0d actual=%0b expected=%0b", e.tag, fetch_pc, access_l1, e.miss);
        end
        total++;
        if (fetch_words !== e.data) begin
          bad++;
          $display("FAIL %s data pc=%0d actual=%h expected=%h", e.tag, fetch_pc, fetch_words, e.data);
        end
      end
    end else if (rst_n && !done) begin
      total++;
      if (access_l1 !== 1'b0) begin
        bad++;
        $display("FAIL R11 idle access_l1 actual=%0b expected=0", access_l1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 first fetch, R11 idle hold, R2 in-line, R3 next-line bit
    fetch(0, 0, 0, 1, "R1");
    idle(3);
    fetch(2, 0, 0, 0, "R2 R11");
    fetch(4, 0, 0, 1, "R3");
    fetch(6, 2, 0, 0, "R2");
    fetch(8, 2, 0, 1, "R8");
    fetch(0, 0, 0, 1, "R8 R9");
    fetch(2, 0, 0, 0, "R2");
    fetch(4, 0, 0, 0, "R3 R9");
    fetch(6, 2, 0, 0, "R2");
    // R4 replace second line of the pair
    fetch(68, 2, 0, 1, "R4");
    fetch(0, 0, 0, 1, "R8");
    fetch(2, 0, 0, 0, "R2");
    fetch(4, 0, 0, 1, "R4");
    fetch(6, 2, 0, 0, "R10");
    // R5 direct transfer slot 0 -> 40
    fetch(2, 1, 0, 1, "R5");
    fetch(40, 0, 0, 1, "R5");
    fetch(42, 2, 0, 0, "R2");
    fetch(2, 1, 0, 1, "R8");
    fetch(40, 2, 0, 0, "R5");
    // R7 transfer in slot 1 has its own bit
    fetch(3, 1, 1, 1, "R8 R10");
    fetch(40, 2, 0, 1, "R7");
    fetch(2, 1, 0, 1, "R8");
    fetch(40, 2, 0, 0, "R7");
    fetch(3, 1, 1, 1, "R8");
    fetch(40, 2, 0, 0, "R7");
    // R6 replace the target line
    fetch(104, 2, 0, 1, "R6");
    fetch(2, 1, 0, 1, "R8");
    fetch(40, 2, 0, 1, "R6");
    // R7 sequential position is group end
    fetch(1, 0, 0, 1, "R8");
    fetch(2, 2, 0, 0, "R7");
    idle(3);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: leftover actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule